// File: doc/BRIEF.md
# Keyed Periodic Interrupt Timer

This block produces a regular interrupt from a 16-bit down-counter. Software writes a reload value, and the counter counts down one step per timer tick. On the tick after it reaches zero it reloads and raises a sticky status flag. While interrupt enable is set, that flag drives the interrupt request line. The block derives the timer tick from an external clock-enable pulse. A configuration input selects whether it divides that pulse by a small ratio or a large one.

A small register bus has four addresses. The control register holds an 8-bit request level, the status flag, and the interrupt, freeze and run enables. It is write-protected: writes take effect only after a key word has been written to the key register. A debug freeze input halts counting when the freeze enable is set. Hard reset clears every register. Soft reset only restarts the tick divider.

Top module: `periodic_tick_timer`

## Requirements
- R1: With run enabled, a reload value N gives one expiry every N+1 timer ticks. Each expiry sets the status flag and reloads N.
- R2: While the run enable is 0, the counter keeps its value and no expiry occurs.
- R3: A write to the reload register (address 1) loads the counter on the next clock edge, including while counting. A tick in that same cycle is discarded.
- R4: Reads of any address (0 control, 1 reload, 2 key, 3 live counter, read-only) change neither the count nor the status. Read data appears on the cycle after the read strobe.
- R5: Control word layout, in bits numbered from 0 at the LSB: [15:8] request level (also driven on `irq_level`), [7] status, [6:3] reserved (they read 0), [2] interrupt enable, [1] freeze enable, [0] run enable.
- R6: Writing 1 to control bit 7 clears the status flag, and writing 0 leaves it as it is. If an expiry and a clearing write fall in the same cycle, the flag ends set.
- R7: Hard reset clears control, status, reload, counter and key state. Soft reset restarts only the tick divider and leaves all registers unchanged.
- R8: Control writes are ignored while locked. Writing 0x55CCAA33 to the key register unlocks it. Any other value written there locks it again. Bit 0 of a key read shows the unlocked state.
- R9: The timer tick occurs once per 4 external pulses when `div_sel` is 0, and once per 128 pulses when it is 1.
- R10: `irq` is high exactly while the status flag and the interrupt enable are both 1.
- R11: With the freeze enable set, an asserted `freeze_in` holds the counter, and counting resumes when it is released. With the freeze enable clear, `freeze_in` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Hard reset, synchronous, active high |
| soft_rst | input | 1 | Soft reset, synchronous, active high; restarts the divider only |
| ext_tick | input | 1 | One pulse per external timer clock period |
| div_sel | input | 1 | Divider select: 0 for 4, 1 for 128 |
| freeze_in | input | 1 | Debug freeze request |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Interrupt request |
| irq_level | output | 8 | Configured request level |

## Verification
An expiry that sets the status flag and a software write that clears it can fall in the same clock cycle. The bench stops the external pulses, restarts the divider with a soft reset, and loads a reload value of zero. It then applies exactly three pulses, so the fourth pulse produces an expiry. It drives that fourth pulse in the same cycle as a write-one-to-clear. The flag must read back as set and `irq` must stay high. A clearing write issued with no tick in its cycle is the control case, and it must leave the flag clear.

// File: rtl/ptt_pkg.sv
`timescale 1ns/1ps
package ptt_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;
    localparam int LVL_W  = 8;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_RELOAD = 2'd1,
        REG_KEY    = 2'd2,
        REG_COUNT  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic             irq_en;
        logic             frz_en;
        logic             run_en;
    } ctrl_t;

    function automatic logic [15:0] pack_ctrl(input ctrl_t c, input logic status);
        return {c.level, status, 4'b0000, c.irq_en, c.frz_en, c.run_en};
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [15:0] w);
        ctrl_t c;
        c.level  = w[15:8];
        c.irq_en = w[2];
        c.frz_en = w[1];
        c.run_en = w[0];
        return c;
    endfunction
endpackage

// File: rtl/ptt_prescaler.sv
`timescale 1ns/1ps
module ptt_prescaler #(
    parameter int DIV_FAST = 4,
    parameter int DIV_SLOW = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic soft_rst,
    input  logic ext_tick,
    input  logic div_sel,
    output logic tick
);
    localparam int PW = $clog2(DIV_SLOW);

    logic [PW-1:0] phase;
    logic [PW-1:0] limit;

    always_comb limit = div_sel ? PW'(DIV_SLOW - 1) : PW'(DIV_FAST - 1);

    // a phase beyond the limit (after a ratio change) wraps at once
    assign tick = ext_tick && (phase >= limit);

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            phase <= '0;
        end else if (ext_tick) begin
            phase <= (phase >= limit) ? '0 : phase + 1'b1;
        end
    end

    // R9: ticks are always separated by at least one idle cycle
    p_tick_gap_r9: assert property (@(posedge clk) disable iff (rst || soft_rst)
        tick |=> !tick);
endmodule

// File: rtl/ptt_counter.sv
`timescale 1ns/1ps
module ptt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic at_zero;
    assign at_zero = (count == '0);
    assign expire  = advance && !load && at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (advance) begin
            count <= at_zero ? reload : count - 1'b1;
        end
    end

    p_reload_r1: assert property (@(posedge clk) disable iff (rst)
        advance && !load && count == '0 |=> count == $past(reload));
    p_step_r1: assert property (@(posedge clk) disable iff (rst)
        advance && !load && count != '0 |=> count == $past(count) - 1'b1);
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !advance && !load |=> $stable(count));
    p_load_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(load_val));
endmodule

// File: rtl/ptt_regs.sv
`timescale 1ns/1ps
module ptt_regs
    import ptt_pkg::*;
#(
    parameter int          CNT_W = 16,
    parameter logic [31:0] KEY   = 32'h55CC_AA33
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              expire,
    output ctrl_t             ctrl,
    output logic              status,
    output logic [CNT_W-1:0]  reload,
    output logic              load,
    output logic [DATA_W-1:0] rdata
);
    reg_sel_e sel;
    logic     unlocked;
    logic     ctrl_wr;
    logic     key_wr;

    assign sel     = reg_sel_e'(addr);
    assign ctrl_wr = wr && (sel == REG_CTRL) && unlocked;
    assign key_wr  = wr && (sel == REG_KEY);
    assign load    = wr && (sel == REG_RELOAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            unlocked <= 1'b0;
        end else if (key_wr) begin
            unlocked <= (wdata == KEY);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl <= unpack_ctrl(wdata[15:0]);
        end
    end

    // an expiry outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= 1'b0;
        end else if (expire) begin
            status <= 1'b1;
        end else if (ctrl_wr && wdata[7]) begin
            status <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload <= '0;
        end else if (load) begin
            reload <= wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd) begin
            unique case (sel)
                REG_CTRL:   rdata <= DATA_W'(pack_ctrl(ctrl, status));
                REG_RELOAD: rdata <= DATA_W'(reload);
                REG_KEY:    rdata <= DATA_W'(unlocked);
                REG_COUNT:  rdata <= DATA_W'(count);
            endcase
        end
    end

    p_locked_ignore_r8: assert property (@(posedge clk) disable iff (rst)
        wr && sel == REG_CTRL && !unlocked |=> $stable(ctrl));
    p_bad_key_r8: assert property (@(posedge clk) disable iff (rst)
        key_wr && wdata != KEY |=> !unlocked);
    p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
        expire |=> status);
    p_write0_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr && !wdata[7] && status |=> status);
endmodule

// File: rtl/periodic_tick_timer.sv
`timescale 1ns/1ps
module periodic_tick_timer
    import ptt_pkg::*;
#(
    parameter int          CNT_W    = 16,
    parameter int          DIV_FAST = 4,
    parameter int          DIV_SLOW = 128,
    parameter logic [31:0] KEY      = 32'h55CC_AA33
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              ext_tick,
    input  logic              div_sel,
    input  logic              freeze_in,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic [LVL_W-1:0]  irq_level
);
    ctrl_t            ctrl;
    logic             status;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] count;
    logic             load;
    logic             expire;
    logic             tick;
    logic             frozen;
    logic             advance;

    ptt_prescaler #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_div (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .ext_tick(ext_tick), .div_sel(div_sel), .tick(tick)
    );

    assign frozen  = ctrl.frz_en && freeze_in;
    assign advance = tick && ctrl.run_en && !frozen;

    ptt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .advance(advance), .load(load),
        .load_val(bus_wdata[CNT_W-1:0]), .reload(reload),
        .count(count), .expire(expire)
    );

    ptt_regs #(.CNT_W(CNT_W), .KEY(KEY)) u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
        .wdata(bus_wdata), .count(count), .expire(expire),
        .ctrl(ctrl), .status(status), .reload(reload), .load(load),
        .rdata(bus_rdata)
    );

    assign irq       = status && ctrl.irq_en;
    assign irq_level = ctrl.level;

    p_freeze_hold_r11: assert property (@(posedge clk) disable iff (rst)
        frozen && !load |=> $stable(count));
    p_irq_drop_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(status) |-> !irq);
    p_stopped_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !ctrl.run_en |-> !expire);
endmodule

// File: tb/test_periodic_tick_timer.sv
`timescale 1ns/1ps
module test_periodic_tick_timer;
    localparam logic [31:0] KEY = 32'h55CC_AA33;
    localparam logic [1:0] A_CTRL = 2'd0, A_RELOAD = 2'd1, A_KEY = 2'd2, A_COUNT = 2'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1, soft_rst = 1'b0, ext_tick = 1'b1, div_sel = 1'b0, freeze_in = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic [7:0]  irq_level;

    always #2 clk = ~clk;

    periodic_tick_timer i_periodic_tick_timer (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .ext_tick(ext_tick),
        .div_sel(div_sel), .freeze_in(freeze_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .irq_level(irq_level)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [31:0] lo;
        logic [31:0] hi;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    logic rd_seen = 1'b0;
    always @(posedge clk) rd_seen <= bus_rd;

    // monitor: one expected item per completed read
    always @(negedge clk) begin
        if (rd_seen) begin
            exp_t e;
            checks++;
            if (sbq.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: read %h with nothing expected", bus_rdata);
            end else begin
                e = sbq.pop_front();
                if (bus_rdata < e.lo || bus_rdata > e.hi) begin
                    errors++;
                    $display("FAIL %s: read %h expected %h..%h", e.tag, bus_rdata, e.lo, e.hi);
                end
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run still busy (actual hung, expected done)");
        finish_run();
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] lo, input logic [31:0] hi, input string tag);
        exp_t e;
        e.lo = lo; e.hi = hi; e.tag = tag;
        @(negedge clk);
        sbq.push_back(e);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_rise(input string tag, input int limit, output int stamp);
        logic prev;
        prev  = irq;
        stamp = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (irq && !prev) begin
                stamp = cyc;
                break;
            end
            prev = irq;
        end
        if (stamp < 0) begin
            checks++;
            errors++;
            $display("FAIL %s: no interrupt edge in %0d cycles (actual none, expected edge)", tag, limit);
        end
    endtask

    task automatic pulse_soft();
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
    endtask

    int t0, t1, w;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R7 hard reset state
        rd(A_CTRL, 0, 0, "R7 ctrl after reset");
        rd(A_RELOAD, 0, 0, "R7 reload after reset");
        rd(A_KEY, 0, 0, "R7 locked after reset");
        rd(A_COUNT, 0, 0, "R7 count after reset");
        chk("R7 irq after reset", irq, 0);
        chk("R7 level after reset", irq_level, 0);

        // R8 lock
        wr(A_CTRL, 32'h0000_AB05);
        rd(A_CTRL, 0, 0, "R8 locked write ignored");
        chk("R8 level unchanged while locked", irq_level, 0);
        wr(A_KEY, KEY);
        rd(A_KEY, 1, 1, "R8 unlocked");
        // R5 layout, reserved bits read 0
        wr(A_CTRL, 32'h5A78);
        rd(A_CTRL, 32'h5A00, 32'h5A00, "R5 ctrl layout");
        chk("R5 irq_level", irq_level, 8'h5A);
        wr(A_KEY, 32'h1234_5678);
        rd(A_KEY, 0, 0, "R8 relocked");
        wr(A_CTRL, 32'hFFFF);
        rd(A_CTRL, 32'h5A00, 32'h5A00, "R8 relocked write ignored");
        wr(A_KEY, KEY);

        // R3 load, R2 hold while stopped
        wr(A_RELOAD, 5);
        rd(A_COUNT, 5, 5, "R3 load while stopped");
        repeat (40) @(negedge clk);
        rd(A_COUNT, 5, 5, "R2 stopped count holds");
        rd(A_RELOAD, 5, 5, "R4 reload readback");

        // R1 period with R4 reads in between
        wr(A_CTRL, 32'h5A05);
        wait_rise("R1 first expiry", 100, t0);
        rd(A_CTRL, 32'h5A85, 32'h5A85, "R1 status set on expiry");
        rd(A_COUNT, 0, 5, "R4 live count read");
        wr(A_CTRL, 32'h5A85);
        chk("R6 clear drops irq", irq, 0);
        wait_rise("R1 second expiry", 100, t1);
        chk("R1 period (N+1)*4 with reads R4", t1 - t0, 24);
        wr(A_CTRL, 32'h5A05);
        rd(A_CTRL, 32'h5A85, 32'h5A85, "R6 writing 0 keeps status");

        // R10 gating
        wr(A_CTRL, 32'h5A01);
        chk("R10 irq off with enable 0", irq, 0);
        rd(A_CTRL, 32'h5A81, 32'h5A81, "R10 status still set");
        wr(A_CTRL, 32'h5A05);
        chk("R10 irq on with enable 1", irq, 1);

        // R2 stopped: no expiry
        wr(A_CTRL, 32'h5A04);
        wr(A_CTRL, 32'h5A84);
        wr(A_RELOAD, 9);
        repeat (50) @(negedge clk);
        rd(A_COUNT, 9, 9, "R2 count holds, R3 loaded");
        chk("R2 no expiry while stopped", irq, 0);

        // R3 load while counting
        wr(A_RELOAD, 1000);
        wr(A_CTRL, 32'h5A85);
        repeat (20) @(negedge clk);
        wr(A_RELOAD, 7);
        w = cyc - 1;
        wait_rise("R3 expiry after reload write", 60, t0);
        checks++;
        if (t0 - w < 30 || t0 - w > 33) begin
            errors++;
            $display("FAIL R3: expiry %0d cycles after write expected 30..33", t0 - w);
        end

        // R11 freeze
        wr(A_CTRL, 32'h5A87);
        @(negedge clk); freeze_in = 1'b1;
        wr(A_RELOAD, 20);
        repeat (60) @(negedge clk);
        rd(A_COUNT, 20, 20, "R11 frozen count holds");
        wr(A_CTRL, 32'h5A05);
        repeat (20) @(negedge clk);
        rd(A_COUNT, 10, 19, "R11 freeze ignored when disabled");
        wr(A_CTRL, 32'h5A07);
        @(negedge clk); freeze_in = 1'b0;
        wr(A_RELOAD, 20);
        repeat (20) @(negedge clk);
        rd(A_COUNT, 10, 19, "R11 resumes after release");

        // R7 soft reset, R9 slow divider
        wr(A_CTRL, 32'h5A04);
        wr(A_CTRL, 32'h5A84);
        div_sel = 1'b1;
        pulse_soft();
        rd(A_CTRL, 32'h5A04, 32'h5A04, "R7 soft reset keeps ctrl");
        rd(A_KEY, 1, 1, "R7 soft reset keeps key");
        rd(A_RELOAD, 20, 20, "R7 soft reset keeps reload");
        wr(A_RELOAD, 1);
        wr(A_CTRL, 32'h5A85);
        wait_rise("R9 slow expiry 1", 600, t0);
        wr(A_CTRL, 32'h5A85);
        wait_rise("R9 slow expiry 2", 600, t1);
        chk("R9 divide by 128 period", t1 - t0, 256);

        // R6 same-cycle expiry and clear
        ext_tick = 1'b0;
        div_sel  = 1'b0;
        wr(A_CTRL, 32'h5A84);
        wr(A_RELOAD, 0);
        wr(A_CTRL, 32'h5A85);
        pulse_soft();
        @(negedge clk); ext_tick = 1'b1;
        repeat (3) @(negedge clk);
        ext_tick = 1'b0;
        rd(A_CTRL, 32'h5A05, 32'h5A05, "R9 no tick after 3 pulses");
        chk("R9 irq low before 4th pulse", irq, 0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = 32'h5A85; ext_tick = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; ext_tick = 1'b0;
        rd(A_CTRL, 32'h5A85, 32'h5A85, "R6 expiry wins over clear");
        chk("R6 irq stays high", irq, 1);
        wr(A_CTRL, 32'h5A85);
        rd(A_CTRL, 32'h5A05, 32'h5A05, "R6 plain clear");
        chk("R6 irq low after plain clear", irq, 0);

        repeat (4) @(negedge clk);
        if (sbq.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: %0d reads never answered (expected 0)", sbq.size());
        end
        finish_run();
    end
endmodule